// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a memory-mapped watchdog timer with a 32-bit down-counter. Software programs a reload value, then enables the interrupt. From that point the counter counts down on its own clock. Each time it reaches zero it reloads. The first time-out raises an interrupt. If that interrupt is still pending at the next time-out and the reset enable is set, the block drives a reset pulse of fixed length.

Enabling the interrupt locks the control register until the next hardware reset. A write to the clear location acknowledges the interrupt and restarts the count.

The bus side and the counter side run on separate clocks. Every accepted register write is carried across with a toggle handshake. A read-only completion flag in the control word reports when that write has taken effect on the counter side. Writes that arrive while the flag is low are dropped.

Top module: `wdt_twostage`

## Requirements
- R1: After `rst_n` is released, the control word reads 0x80000000 (bit 31 completion flag = 1, bit 1 reset enable = 0, bit 0 interrupt enable = 0), and `irq` and `wdt_rst` are 0.
- R2: The register offsets are: reload value at 0x0 (read/write), current count at 0x4 (read only), control at 0x8, clear at 0xC. The clear location reads 0, and control bits 30..2 read 0 whatever was written to them.
- R3: A write to 0x0 sets both the reload value and the current count to the written value.
- R4: While interrupt enable (control bit 0) is 0, the count does not change.
- R5: The completion flag (control bit 31) reads 0 in the bus cycle after a write is accepted, and returns to 1 after the handshake comes back. A write issued while the flag is 0 is dropped.
- R6: Once interrupt enable is 1, writes to 0x8 are ignored and leave the completion flag at 1. Only `rst_n` clears the enable and restores write access.
- R7: With interrupt enable set, the count decrements once per counter clock. When it is 0, a time-out occurs: the count reloads and `irq` is set. A time-out therefore repeats every reload+1 counter clocks.
- R8: Any write to 0xC clears `irq` and reloads the count from the reload value.
- R9: A time-out that finds `irq` already set asserts `wdt_rst` for exactly RST_PULSE counter clocks, but only when reset enable (control bit 1) is 1. With reset enable at 0, no pulse occurs.
- R10: A write to the count location 0x4 is not accepted: the completion flag stays 1 and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| cclk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low, both domains |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Time-out interrupt, counter domain |
| wdt_rst | output | 1 | Reset pulse on second time-out, counter domain |

## Verification
The bench builds the block with RST_PULSE = 5, keeps the default two-stage synchronizers, and programs a reload value of 60. With these settings both time-outs and the full reset pulse occur within a few hundred counter clocks. This makes the exact interval between the first and second time-out, and the exact pulse width, measurable in counter clocks. The bus clock runs at 100 MHz and the counter clock at an unrelated 13 ns period, so the handshake latency varies from one write to the next. For that reason, checks that span the crossing use bounded windows, while checks within the counter domain are exact.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_LOAD = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 4'hC;

  typedef enum logic [1:0] {K_LOAD, K_CTRL, K_CLEAR, K_NONE} wkind_e;

  function automatic logic [DW-1:0] ctrl_word(logic done, logic resen, logic inten);
    return {done, {(DW-3){1'b0}}, resen, inten};
  endfunction

  function automatic logic [DW-1:0] next_count(logic [DW-1:0] cnt, logic [DW-1:0] load);
    return (cnt == '0) ? load : cnt - 1'b1;
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_bus_side.sv
module wdt_bus_side
  import wdt_pkg::*;
#(
  parameter logic [DW-1:0] LOAD_RESET = '1
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              ack_tog_s,
  input  logic [DW-1:0]     cnt_s,
  output logic [DW-1:0]     bus_rdata,
  output logic              req_tog,
  output wkind_e            hold_kind,
  output logic [DW-1:0]     hold_data,
  output logic              ctrl_inten,
  output logic              ctrl_resen,
  output logic              wrc,
  output logic              wr_accept
);
  logic [DW-1:0] load_b;
  wkind_e        kind;

  assign wrc = (req_tog == ack_tog_s);

  always_comb begin
    unique case (bus_addr)
      OFS_LOAD: kind = K_LOAD;
      OFS_CTRL: kind = ctrl_inten ? K_NONE : K_CTRL;
      OFS_CLR:  kind = K_CLEAR;
      default:  kind = K_NONE;
    endcase
  end

  assign wr_accept = bus_we && wrc && (kind != K_NONE);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tog    <= 1'b0;
      hold_kind  <= K_NONE;
      hold_data  <= '0;
      ctrl_inten <= 1'b0;
      ctrl_resen <= 1'b0;
      load_b     <= LOAD_RESET;
    end else if (wr_accept) begin
      req_tog   <= ~req_tog;
      hold_kind <= kind;
      hold_data <= bus_wdata;
      if (kind == K_LOAD) load_b <= bus_wdata;
      if (kind == K_CTRL) begin
        ctrl_inten <= bus_wdata[0];
        ctrl_resen <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_LOAD: bus_rdata = load_b;
      OFS_CNT:  bus_rdata = cnt_s;
      OFS_CTRL: bus_rdata = ctrl_word(wrc, ctrl_resen, ctrl_inten);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
  import wdt_pkg::*;
#(
  parameter logic [DW-1:0] LOAD_RESET = '1,
  parameter int            RST_PULSE  = 16
) (
  input  logic          cclk,
  input  logic          rst_n,
  input  logic          req_tog_s,
  input  wkind_e        hold_kind,
  input  logic [DW-1:0] hold_data,
  output logic          ack_tog,
  output logic [DW-1:0] cnt,
  output logic          irq,
  output logic          wdt_rst,
  output logic          inten_c,
  output logic          resen_c,
  output logic          clear_evt
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic          req_seen;
  logic          apply_evt;
  logic          timeout_evt;
  logic          second_evt;
  logic [DW-1:0] load_c;
  logic [PW-1:0] rst_left;

  assign apply_evt   = req_tog_s ^ req_seen;
  assign clear_evt   = apply_evt && (hold_kind == K_CLEAR);
  assign timeout_evt = inten_c && (cnt == '0) && !apply_evt;
  assign second_evt  = timeout_evt && irq && resen_c;
  assign ack_tog     = req_seen;
  assign wdt_rst     = (rst_left != '0);

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      load_c   <= LOAD_RESET;
      cnt      <= LOAD_RESET;
      irq      <= 1'b0;
      inten_c  <= 1'b0;
      resen_c  <= 1'b0;
    end else if (apply_evt) begin
      req_seen <= req_tog_s;
      unique case (hold_kind)
        K_LOAD: begin
          load_c <= hold_data;
          cnt    <= hold_data;
        end
        K_CTRL: begin
          inten_c <= hold_data[0];
          resen_c <= hold_data[1];
        end
        K_CLEAR: begin
          irq <= 1'b0;
          cnt <= load_c;
        end
        default: ;
      endcase
    end else if (inten_c) begin
      cnt <= next_count(cnt, load_c);
      if (timeout_evt) irq <= 1'b1;
    end
  end

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n)                rst_left <= '0;
    else if (second_evt)       rst_left <= PW'(RST_PULSE);
    else if (rst_left != '0)   rst_left <= rst_left - 1'b1;
  end
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter logic [DW-1:0] LOAD_RESET  = '1,
  parameter int            RST_PULSE   = 16,
  parameter int            SYNC_STAGES = 2
) (
  input  logic              bclk,
  input  logic              cclk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              wdt_rst
);
  logic          req_tog, req_tog_s, ack_tog, ack_tog_s;
  logic          ctrl_inten, ctrl_resen, wrc, wr_accept;
  logic          inten_c, resen_c, clear_evt;
  wkind_e        hold_kind;
  logic [DW-1:0] hold_data, cnt, cnt_s;

  wdt_bus_side #(.LOAD_RESET(LOAD_RESET)) u_bus (
    .bclk, .rst_n, .bus_addr, .bus_we, .bus_wdata,
    .ack_tog_s, .cnt_s, .bus_rdata, .req_tog, .hold_kind, .hold_data,
    .ctrl_inten, .ctrl_resen, .wrc, .wr_accept
  );

  wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(cclk), .rst_n, .d(req_tog), .q(req_tog_s)
  );

  wdt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bclk), .rst_n, .d(ack_tog), .q(ack_tog_s)
  );

  wdt_sync #(.WIDTH(DW), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(bclk), .rst_n, .d(cnt), .q(cnt_s)
  );

  wdt_count_core #(.LOAD_RESET(LOAD_RESET), .RST_PULSE(RST_PULSE)) u_core (
    .cclk, .rst_n, .req_tog_s, .hold_kind, .hold_data,
    .ack_tog, .cnt, .irq, .wdt_rst, .inten_c, .resen_c, .clear_evt
  );
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk
  import wdt_pkg::*;
(
  input logic              bclk,
  input logic              cclk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_accept,
  input logic              wrc,
  input logic              ctrl_inten,
  input logic              ctrl_resen,
  input logic [DW-1:0]     hold_data,
  input logic              irq,
  input logic              wdt_rst,
  input logic              inten_c,
  input logic              resen_c,
  input logic              clear_evt
);
  assert_accept_clears_flag_R5: assert property (@(posedge bclk) disable iff (!rst_n)
    wr_accept |=> !wrc);

  assert_hold_stable_R5: assert property (@(posedge bclk) disable iff (!rst_n)
    !wrc |=> $stable(hold_data));

  assert_lock_sticky_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    ctrl_inten |=> ctrl_inten);

  assert_locked_write_ignored_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CTRL && ctrl_inten && wrc) |=> (wrc && $stable(ctrl_resen)));

  assert_irq_needs_enable_R7: assert property (@(posedge cclk) disable iff (!rst_n)
    $rose(irq) |-> inten_c);

  assert_clear_drops_irq_R8: assert property (@(posedge cclk) disable iff (!rst_n)
    clear_evt |=> !irq);

  assert_reset_needs_pending_R9: assert property (@(posedge cclk) disable iff (!rst_n)
    $rose(wdt_rst) |-> (irq && resen_c));
endmodule

bind wdt_twostage wdt_twostage_chk u_chk (
  .bclk(bclk), .cclk(cclk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wr_accept(wr_accept), .wrc(wrc), .ctrl_inten(ctrl_inten), .ctrl_resen(ctrl_resen),
  .hold_data(hold_data), .irq(irq), .wdt_rst(wdt_rst), .inten_c(inten_c),
  .resen_c(resen_c), .clear_evt(clear_evt)
);

// File: tb/wdt_twostage_test.sv
`timescale 1ns/1ps
module wdt_twostage_test;
  import wdt_pkg::*;

  localparam int          PULSE = 5;
  localparam logic [31:0] L     = 32'd60;

  logic        bclk = 0, cclk = 0, rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_rst;
  int total = 0, bad = 0;

  always #5 bclk = ~bclk;
  always #6.5 cclk = ~cclk;

  wdt_twostage #(.RST_PULSE(PULSE)) uut (
    .bclk, .cclk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata, .irq, .wdt_rst
  );

  // vector: {write addr, read addr, write data, expected read}
  localparam logic [71:0] VEC [6] = '{
    {4'h0, 4'h0, 32'h0000_0050, 32'h0000_0050},  // R2 R3 reload readback
    {4'h0, 4'h4, 32'h0000_1234, 32'h0000_1234},  // R3 count follows reload write
    {4'h8, 4'h8, 32'h7FFF_FFFE, 32'h8000_0002},  // R2 reserved bits read zero
    {4'h8, 4'h8, 32'h0000_0000, 32'h8000_0000},  // R6 writable before lock
    {4'hC, 4'hC, 32'h0000_DEAD, 32'h0000_0000},  // R2 clear location reads zero
    {4'h0, 4'h4, 32'h0000_0040, 32'h0000_0040}   // R3 count follows reload write
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw_reset();
    bus_we = 0;
    rst_n = 0;
    repeat (3) @(negedge bclk);
    rst_n = 1;
    repeat (2) @(negedge bclk);
  endtask

  task automatic bw(logic [3:0] a, logic [31:0] d);
    @(negedge bclk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge bclk);
    bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    logic ok;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge bclk);
      rd(OFS_CTRL, v);
      if (v[31]) begin ok = 1; break; end
    end
    chk("R5 completion flag returns", {31'd0, ok}, 32'd1);
    repeat (6) @(negedge bclk);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    logic saw_rst;

    // ---------- session A ----------
    hw_reset();
    rd(OFS_CTRL, v); chk("R1 control after reset", v, 32'h8000_0000);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 wdt_rst after reset", {31'd0, wdt_rst}, 32'd0);

    foreach (VEC[i]) begin
      bw(VEC[i][71:68], VEC[i][63:32]);
      wait_done();
      rd(VEC[i][67:64], v);
      chk($sformatf("R2/R3 vector %0d", i), v, VEC[i][31:0]);
    end

    // R4: enable off, count frozen
    repeat (50) @(negedge bclk);
    rd(OFS_CNT, v); chk("R4 count frozen while disabled", v, 32'h40);

    // R5: flag drops after accept, write while busy is dropped
    bw(OFS_LOAD, 32'h0000_0077);
    rd(OFS_CTRL, v); chk("R5 flag low after write", {31'd0, v[31]}, 32'd0);
    bw(OFS_LOAD, 32'h0000_0099);
    wait_done();
    rd(OFS_LOAD, v); chk("R5 busy write dropped (reload)", v, 32'h77);
    rd(OFS_CNT, v);  chk("R5 busy write dropped (count)", v, 32'h77);

    // R10: count location is read only
    bw(OFS_CNT, 32'h0000_0005);
    rd(OFS_CTRL, v); chk("R10 flag stays high", {31'd0, v[31]}, 32'd1);
    repeat (8) @(negedge bclk);
    rd(OFS_CNT, v); chk("R10 count unchanged", v, 32'h77);

    // enable interrupt only, then try to change control
    bw(OFS_LOAD, L); wait_done();
    bw(OFS_CTRL, 32'h1); wait_done();
    bw(OFS_CTRL, 32'h2);
    rd(OFS_CTRL, v); chk("R6 locked write ignored", v, 32'h8000_0001);

    k = 0;
    while (!irq && k < 500) begin @(negedge cclk); k++; end
    chk("R7 first time-out raises irq", {31'd0, irq}, 32'd1);
    chk("R7 time-out near reload+1", {31'd0, (k >= L - 20 && k <= L + 1)}, 32'd1);

    saw_rst = 0;
    for (int i = 0; i < 2 * L + 10; i++) begin
      @(negedge cclk);
      if (wdt_rst) saw_rst = 1;
    end
    chk("R9 no reset pulse with reset enable 0", {31'd0, saw_rst}, 32'd0);
    chk("R9 irq still pending", {31'd0, irq}, 32'd1);

    bw(OFS_CLR, 32'h0);
    wait_done();
    chk("R8 clear drops irq", {31'd0, irq}, 32'd0);
    rd(OFS_CNT, v);
    chk("R8 count reloaded", {31'd0, (v <= L && v >= L - 20)}, 32'd1);

    k = 0;
    while (!irq && k < 500) begin @(negedge cclk); k++; end
    chk("R7 reload then next time-out", {31'd0, (irq && k <= L + 1)}, 32'd1);

    // hardware reset restores write access
    hw_reset();
    rd(OFS_CTRL, v); chk("R6 reset unlocks control", v, 32'h8000_0000);
    bw(OFS_CTRL, 32'h2); wait_done();
    rd(OFS_CTRL, v); chk("R6 control writable again", v, 32'h8000_0002);

    // ---------- session B: reset enabled ----------
    hw_reset();
    bw(OFS_LOAD, L); wait_done();
    bw(OFS_CTRL, 32'h3); wait_done();
    rd(OFS_CTRL, v); chk("R6 both enables read back", v, 32'h8000_0003);

    k = 0;
    while (!irq && k < 500) begin @(negedge cclk); k++; end
    chk("R7 irq on first time-out", {31'd0, irq}, 32'd1);
    chk("R9 no pulse on first time-out", {31'd0, wdt_rst}, 32'd0);

    k = 0;
    while (!wdt_rst && k < 500) begin @(negedge cclk); k++; end
    chk("R7/R9 second time-out interval", k, L + 1);

    k = 0;
    while (wdt_rst && k < 100) begin @(negedge cclk); k++; end
    chk("R9 reset pulse width", k, PULSE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule